// File: doc/BRIEF.md
# Load/Store Address and Part-Word Unit

This unit sits between a register file and a synchronous data memory. For each memory request it works out the effective address from a base register and a signed offset. It also decides whether the base register receives an updated value, and it produces that value. For stores, it steers the word, halfword or byte of the source register onto the correct byte lanes of a 32-bit big-endian memory word and raises the matching byte enables. For loads, it takes the raw word the memory returns, picks the addressed halfword or byte, and places it in the low bits of the result. The upper bits are filled with zeros or with copies of the sign bit.

A request is presented for one cycle with `req_valid`. The memory-side outputs and the writeback outputs are registered and appear in the next cycle. The memory is expected to return its read word on `rd_word` in the cycle after it sees `mem_en`. The extracted load result appears on `ld_data`, with `ld_valid` high, one cycle after that. A halfword or word request whose address is not naturally aligned raises `misalign_err` and produces neither a memory access nor a writeback.

Top module: `ls_agu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs `mem_en`, `mem_we`, `mem_be`, `wb_en`, `misalign_err` and `ld_valid` are 0.
- R2: `mode[1]` selects the address. When it is 0, `mem_addr` is `base`. When it is 1, `mem_addr` is `base` plus the extended offset, computed modulo 2^32.
- R3: When `mode[0]` is 1, `wb_en` is 1 and `wb_value` is `base` plus the extended offset, whatever the value of `mode[1]`. When `mode[0]` is 0, `wb_en` stays 0.
- R4: The 16-bit `offset` is sign-extended to 32 bits before it is added, so offsets with bit 15 set move the address downward.
- R5: The `size` code selects the access width: 2'b01 is a word, 2'b00 is a halfword, 2'b10 is a byte, and 2'b11 is handled as a word.
- R6: Byte lanes are big-endian. `mem_be[3]` covers data bits 31:24 and corresponds to address low bits 00, and `mem_be[0]` covers bits 7:0 and corresponds to 11. A byte access sets only the lane for `mem_addr[1:0]`. A halfword access sets 4'b1100 when `mem_addr[1]` is 0 and 4'b0011 when it is 1. A word access sets 4'b1111.
- R7: `mem_we` equals `req_store` for an issued access. On a store, `mem_wdata` carries `st_src[7:0]` (byte), `st_src[15:0]` (halfword) or all of `st_src` (word) in the enabled lanes, and zeros in the other lanes. On a load, `mem_wdata` is zero.
- R8: For a load, `ld_data` holds the addressed byte or halfword of `rd_word` in its low bits. The upper bits are zero when `zero_ext` is 1 and copies of the part-word's top bit when it is 0. A word load returns `rd_word` unchanged.
- R9: A halfword with `mem_addr[0]`=1, or a word with `mem_addr[1:0]`≠0, raises `misalign_err` in the output cycle and leaves `mem_en`, `mem_we`, `mem_be` and `wb_en` at 0. Byte accesses are never misaligned.
- R10: The memory and writeback outputs appear in the cycle after `req_valid`. For a load, `ld_valid` is 0 in the cycle after `mem_en` and rises in the cycle after that, carrying `ld_data` taken from `rd_word` as it stands in the cycle after `mem_en`.
- R11: In a cycle with no request in the previous cycle, `mem_en`, `wb_en` and `misalign_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| base | input | 32 | Base register value |
| offset | input | 16 | Offset constant, sign-extended internally |
| mode | input | 2 | Bit 1: add the offset to the address; bit 0: write the sum back |
| size | input | 2 | 01 word, 00 halfword, 10 byte, 11 word |
| zero_ext | input | 1 | 1 zero-extends a part-word load, 0 sign-extends it |
| st_src | input | 32 | Store source register value |
| rd_word | input | 32 | Read word from memory, valid the cycle after `mem_en` |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-aligned store data |
| wb_en | output | 1 | Base register writeback strobe |
| wb_value | output | 32 | Base register writeback value |
| misalign_err | output | 1 | Misaligned access, suppressed |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The hardest case to produce is a misaligned request in a writeback mode. In that case the base update must be dropped along with the access, even though the address adder has produced a valid sum. The sweep reaches it by varying the low two bits of the base and of the offset independently across every mode, size, direction and extension setting. Because of this, the effective address lands on every lane both through the base alone and through the sum. Each read word is chosen so that its bytes have changing top bits, which exercises both zero and sign fill in every lane.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_HALF = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int g = 0; g < LANES; g++) m[8*g +: 8] = {8{be[g]}};
    return m;
  endfunction

endpackage

// File: rtl/ls_addr_calc.sv
module ls_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] ea,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_val
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] sum;

  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign sum     = base + off_ext;
  assign ea      = mode[1] ? sum : base;
  assign wb_req  = mode[0];
  assign wb_val  = sum;

endmodule

// File: rtl/ls_store_lane.sv
module ls_store_lane
  import ls_agu_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic              misalign
);
  size_e sz;
  assign sz = size_e'(size);

  always_comb begin
    unique case (sz)
      SZ_BYTE: begin
        be       = 4'b1000 >> lo;
        misalign = 1'b0;
      end
      SZ_HALF: begin
        be       = lo[1] ? 4'b0011 : 4'b1100;
        misalign = lo[0];
      end
      default: begin
        be       = 4'b1111;
        misalign = (lo != 2'b00);
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] pick;
    always_comb begin
      unique case (sz)
        SZ_BYTE: pick = src[7:0];
        SZ_HALF: pick = src[8*(g%2) +: 8];
        default: pick = src[8*g +: 8];
      endcase
    end
    assign wdata[8*g +: 8] = be[g] ? pick : 8'h00;
  end

endmodule

// File: rtl/ls_load_extract.sv
module ls_load_extract
  import ls_agu_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              zext,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  size_e       sz;

  assign sz = size_e'(size);

  always_comb begin
    unique case (lo)
      2'd0:    byte_sel = word[31:24];
      2'd1:    byte_sel = word[23:16];
      2'd2:    byte_sel = word[15:8];
      default: byte_sel = word[7:0];
    endcase
    half_sel = lo[1] ? word[15:0] : word[31:16];
  end

  always_comb begin
    unique case (sz)
      SZ_BYTE: result = {{(DATA_W-8){~zext & byte_sel[7]}}, byte_sel};
      SZ_HALF: result = {{(DATA_W-16){~zext & half_sel[15]}}, half_sel};
      default: result = word;
    endcase
  end

endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic              zero_ext,
  input  logic [DATA_W-1:0] st_src,
  input  logic [DATA_W-1:0] rd_word,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              misalign_err,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic [ADDR_W-1:0] ea, wb_val;
  logic              wb_req;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wdata_c;
  logic              mis_c;
  logic              go;

  ls_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr (
    .base(base), .offset(offset), .mode(mode),
    .ea(ea), .wb_req(wb_req), .wb_val(wb_val)
  );

  ls_store_lane i_store (
    .size(size), .lo(ea[1:0]), .src(st_src),
    .be(be_c), .wdata(wdata_c), .misalign(mis_c)
  );

  assign go = req_valid & ~mis_c;

  // Stage 1: memory-side and writeback outputs
  logic [1:0] s1_size;
  logic       s1_zext;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      wb_en        <= 1'b0;
      wb_value     <= '0;
      misalign_err <= 1'b0;
      s1_size      <= 2'b01;
      s1_zext      <= 1'b0;
    end else begin
      mem_en       <= go;
      mem_we       <= go & req_store;
      mem_addr     <= ea;
      mem_be       <= go ? be_c : '0;
      mem_wdata    <= (go & req_store) ? wdata_c : '0;
      wb_en        <= go & wb_req;
      wb_value     <= wb_val;
      misalign_err <= req_valid & mis_c;
      s1_size      <= size;
      s1_zext      <= zero_ext;
    end
  end

  // Stage 2: wait for the memory read word
  logic       s2_pend;
  logic [1:0] s2_size;
  logic       s2_zext;
  logic [1:0] s2_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_pend <= 1'b0;
      s2_size <= 2'b01;
      s2_zext <= 1'b0;
      s2_lo   <= 2'b00;
    end else begin
      s2_pend <= mem_en & ~mem_we;
      s2_size <= s1_size;
      s2_zext <= s1_zext;
      s2_lo   <= mem_addr[1:0];
    end
  end

  // Stage 3: extracted load result
  logic [DATA_W-1:0] ext_c;

  ls_load_extract i_load (
    .size(s2_size), .zext(s2_zext), .lo(s2_lo), .word(rd_word),
    .result(ext_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= s2_pend;
      if (s2_pend) ld_data <= ext_c;
    end
  end

  AST_MISALIGN_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!mem_en && !mem_we && !wb_en && mem_be == '0)); // R9
  AST_WB_WITH_ACCESS: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> mem_en); // R3
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                mem_be == 4'b0011 || mem_be == 4'b1111)); // R6
  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> (mem_be == '0 && !mem_we)); // R11
  AST_STORE_ZERO_LANES: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata & ~lane_mask(mem_be)) == '0)); // R7
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_en && !mem_we, 2)); // R10
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> !ld_valid || $past(s2_pend)); // R10

endmodule

// File: tb/test_ls_agu.sv
module test_ls_agu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, zero_ext;
  logic [31:0] base, st_src, rd_word;
  logic [15:0] offset;
  logic [1:0]  mode, size;
  logic        mem_en, mem_we, wb_en, misalign_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, wb_value, ld_data;
  logic [3:0]  mem_be;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_agu i_ls_agu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .base(base), .offset(offset), .mode(mode), .size(size),
    .zero_ext(zero_ext), .st_src(st_src), .rd_word(rd_word),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .wb_en(wb_en), .wb_value(wb_value),
    .misalign_err(misalign_err), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(input int i, input logic [1:0] m, input logic [1:0] sz,
                        input logic [1:0] bl, input logic [1:0] ol,
                        input logic st, input logic zx);
    logic [31:0] b, sum, ea, wexp, rdw, lexp, sx;
    logic [15:0] o;
    logic [3:0]  beexp;
    logic        mis, acc;
    int          sh;
    b   = 32'h4000_1000 + 32'(i) * 32'h0001_0104 + 32'(bl);
    b[1:0] = bl;
    o   = 16'(i * 148);
    o[1:0] = ol;
    if (i % 3 == 0) o[15] = 1'b1;
    sx  = {{16{o[15]}}, o};
    sum = b + sx;
    ea  = m[1] ? sum : b;
    rdw = 32'h9C3E_71F5 + 32'(i) * 32'h0107_0923;
    case (sz)
      2'b00:   mis = ea[0];
      2'b10:   mis = 1'b0;
      default: mis = (ea[1:0] != 2'b00);
    endcase
    acc = !mis;
    sh  = 8 * (3 - int'(ea[1:0]));
    case (sz)
      2'b10: begin
        beexp = 4'(1 << (3 - int'(ea[1:0])));
        wexp  = 32'(st_src_of(i) & 32'hFF) << sh;
        lexp  = (rdw >> sh) & 32'hFF;
        if (!zx && lexp[7]) lexp = lexp - 32'h100;
      end
      2'b00: begin
        beexp = ea[1] ? 4'd3 : 4'd12;
        wexp  = (st_src_of(i) & 32'hFFFF) << (ea[1] ? 0 : 16);
        lexp  = (rdw >> (ea[1] ? 0 : 16)) & 32'hFFFF;
        if (!zx && lexp[15]) lexp = lexp - 32'h10000;
      end
      default: begin
        beexp = 4'hF;
        wexp  = st_src_of(i);
        lexp  = rdw;
      end
    endcase
    if (!st) wexp = 32'h0;

    @(negedge clk);
    req_valid = 1'b1; req_store = st; base = b; offset = o; mode = m;
    size = sz; zero_ext = zx; st_src = st_src_of(i);
    @(negedge clk);
    req_valid = 1'b0;
    rd_word   = rdw;
    chk(misalign_err == mis, "R9", "misalign_err", 32'(misalign_err), 32'(mis));
    chk(mem_en == acc, "R10", "mem_en", 32'(mem_en), 32'(acc));
    if (acc) begin
      chk(mem_addr == ea, m[1] ? "R4" : "R2", "mem_addr", mem_addr, ea);
      chk(mem_we == st, "R7", "mem_we", 32'(mem_we), 32'(st));
      chk(mem_be == beexp, sz == 2'b11 ? "R5" : "R6", "mem_be", 32'(mem_be), 32'(beexp));
      chk(mem_wdata == wexp, "R7", "mem_wdata", mem_wdata, wexp);
      chk(wb_en == m[0], "R3", "wb_en", 32'(wb_en), 32'(m[0]));
      if (m[0]) chk(wb_value == sum, "R3", "wb_value", wb_value, sum);
    end else begin
      chk(wb_en == 1'b0 && mem_we == 1'b0 && mem_be == 4'h0, "R9", "suppressed strobes",
          {wb_en, mem_we, 26'h0, mem_be}, 32'h0);
    end
    @(negedge clk);
    chk(ld_valid == 1'b0, "R10", "ld_valid early", 32'(ld_valid), 32'h0);
    chk(mem_en == 1'b0 && wb_en == 1'b0 && misalign_err == 1'b0, "R11", "idle outputs",
        {mem_en, wb_en, misalign_err}, 32'h0);
    @(negedge clk);
    chk(ld_valid == (acc && !st), "R10", "ld_valid", 32'(ld_valid), 32'(acc && !st));
    if (acc && !st) chk(ld_data == lexp, "R8", "ld_data", ld_data, lexp);
  endtask

  function automatic logic [31:0] st_src_of(input int i);
    return 32'hA5C3_8E17 ^ (32'(i) * 32'h0203_0405);
  endfunction

  initial begin
    int i;
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; base = '0; offset = '0;
    mode = '0; size = '0; zero_ext = 1'b0; st_src = '0; rd_word = '0;
    repeat (3) @(negedge clk);
    chk(!mem_en && !mem_we && mem_be == 4'h0 && !wb_en && !misalign_err && !ld_valid,
        "R1", "reset outputs", {mem_en, mem_we, wb_en, misalign_err, ld_valid, 23'h0, mem_be}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_en && !wb_en && !misalign_err && !ld_valid, "R1", "after reset",
        {mem_en, wb_en, misalign_err, ld_valid}, 32'h0);
    i = 0;
    for (int m = 0; m < 4; m++)
      for (int sz = 0; sz < 4; sz++)
        for (int bl = 0; bl < 4; bl++)
          for (int ol = 0; ol < 4; ol++)
            for (int st = 0; st < 2; st++)
              for (int zx = 0; zx < 2; zx++) begin
                run_op(i, 2'(m), 2'(sz), 2'(bl), 2'(ol), 1'(st), 1'(zx));
                i++;
              end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule